// File: doc/BRIEF.md
# Serial Adapter Register and Interrupt Interface

This block is the processor-side register window of a small asynchronous serial adapter used for MIDI traffic. One register-select value reaches a write-only control byte and a read-only status byte. The other reaches the data port: writes go to the transmitter and reads return the most recent received byte. Bit-level serialisation is done elsewhere. A companion transmitter pulses an input when its holding register is free again. A byte-level receive path hands over complete bytes with a valid strobe.

The status byte and the active-low interrupt line come from three pieces of state: the receive-full flag, the transmit-empty flag and the control byte. The interrupt request is recomputed at every clock edge where any of them changes. Both the status bit and the pin therefore follow the state with no extra delay beyond the edge that updates it.

Top module: `acia_regif`

## Requirements
- R1: With `reg_sel`=0 the read bus shows the status byte: bit 7 = interrupt request, bit 1 = transmit empty, bit 0 = receive full, and all other bits 0. With `reg_sel`=1 it shows the received data byte. The read bus is combinational from `reg_sel` and needs no strobe.
- R2: An interrupt is requested while control bit 7 is 1 and the receive-full flag is set.
- R3: An interrupt is requested while control bits 6:5 equal 2'b01 and the transmit-empty flag is set. The encodings 00, 10 and 11 never request one.
- R4: `irq_n` is 0 exactly while a request from R2 or R3 stands, and status bit 7 always equals the inverse of `irq_n`.
- R5: A selected read with `reg_sel`=1 returns the received byte during the strobe cycle and clears receive-full at that edge. The interrupt request is re-evaluated at the same edge.
- R6: A selected write with `reg_sel`=0 stores the whole byte as the control value. Its effect on the interrupt is visible right after that edge.
- R7: After reset the control value is 0x00, the status reads 0x02, the data port reads 0x01 and `irq_n` is 1.
- R8: A `rx_valid` pulse overwrites the received byte and sets receive-full at the next edge. It wins over a data read in the same cycle.
- R9: A selected write with `reg_sel`=1 raises `tx_load` for exactly one cycle after the edge, with `tx_byte` holding the written value, and clears transmit-empty at that same edge. It wins over a `tx_free` pulse in the same cycle.
- R10: A `tx_free` pulse with no data write sets transmit-empty at the next edge.
- R11: Strobes with `cs` low have no effect: the control value and receive-full are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| reg_sel | input | 1 | 0 = control/status, 1 = data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_free | input | 1 | Transmitter holding register freed |
| tx_load | output | 1 | One-cycle load strobe to transmitter |
| tx_byte | output | 8 | Byte for transmitter |

## Verification
Every cycle, the assertions tie the interrupt pin to the control value and both flags in each direction. They also check the update of each flag after receive strobes, data reads, data writes and `tx_free`, and that the control value holds steady while `cs` is low. Some behaviour can only be shown by the bench scenarios: the exact status byte values, the data returned during a read strobe, the overwrite of an unread byte, and the reset contents. The same applies to the two same-cycle collisions, where a new byte beats a read and a data write beats `tx_free`.

// File: rtl/acia_pkg.sv
package acia_pkg;
    localparam int DW        = 8;
    localparam int ST_IRQ    = 7;
    localparam int ST_TXE    = 1;
    localparam int ST_RXF    = 0;
    localparam int CR_RXIE   = 7;
    localparam int CR_TXC_HI = 6;
    localparam int CR_TXC_LO = 5;
    localparam logic [1:0] TXC_IRQ_ON = 2'b01;

    function automatic logic irq_want(input logic [DW-1:0] cr,
                                      input logic rxf, input logic txe);
        logic rx_src;
        logic tx_src;
        rx_src = cr[CR_RXIE] & rxf;
        tx_src = (cr[CR_TXC_HI:CR_TXC_LO] == TXC_IRQ_ON) & txe;
        return rx_src | tx_src;
    endfunction
endpackage

// File: rtl/acia_rx_hold.sv
module acia_rx_hold
    import acia_pkg::*;
#(
    parameter logic [DW-1:0] RX_INIT = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_take,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          rx_full_d
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_take)
            st_d.full = 1'b0;
        if (rx_valid) begin
            st_d.data = rx_byte;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= RX_INIT;
            st_q.full <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data   = st_q.data;
    assign rx_full   = st_q.full;
    assign rx_full_d = st_d.full;

    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !rx_valid) |=> !rx_full); // R5
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (rx_full && rx_data == $past(rx_byte))); // R8
endmodule

// File: rtl/acia_tx_track.sv
module acia_tx_track
    import acia_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_take,
    input  logic [DW-1:0] wr_byte,
    input  logic          tx_free,
    output logic          tx_empty,
    output logic          tx_empty_d,
    output logic          tx_load,
    output logic [DW-1:0] tx_byte
);
    typedef struct packed {
        logic          empty;
        logic          load;
        logic [DW-1:0] hold;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (tx_free)
            st_d.empty = 1'b1;
        if (wr_take) begin
            st_d.empty = 1'b0;
            st_d.load  = 1'b1;
            st_d.hold  = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.empty <= 1'b1;
            st_q.load  <= 1'b0;
            st_q.hold  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_empty   = st_q.empty;
    assign tx_empty_d = st_d.empty;
    assign tx_load    = st_q.load;
    assign tx_byte    = st_q.hold;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> (tx_load && !tx_empty && tx_byte == $past(wr_byte))); // R9
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !wr_take) |=> !tx_load); // R9
    AST_FREE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free && !wr_take) |=> tx_empty); // R10
endmodule

// File: rtl/acia_irq_eval.sv
module acia_irq_eval
    import acia_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctrl_d,
    input  logic          rxf_d,
    input  logic          txe_d,
    output logic          irq
);
    typedef struct packed {
        logic req;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d.req = irq_want(ctrl_d, rxf_d, txe_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.req <= 1'b0;
        else
            st_q <= st_d;
    end

    assign irq = st_q.req;
endmodule

// File: rtl/acia_regif.sv
module acia_regif
    import acia_pkg::*;
#(
    parameter logic [DW-1:0] RX_INIT = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          reg_sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_free,
    output logic          tx_load,
    output logic [DW-1:0] tx_byte
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
    } top_state_t;

    top_state_t    st_d, st_q;
    logic          ctrl_wr, data_wr, data_rd;
    logic [DW-1:0] rx_data;
    logic          rx_full, rx_full_d;
    logic          tx_empty, tx_empty_d;
    logic          irq;
    logic [DW-1:0] status;

    assign ctrl_wr = cs & wr & ~reg_sel;
    assign data_wr = cs & wr &  reg_sel;
    assign data_rd = cs & rd &  reg_sel;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr)
            st_d.ctrl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.ctrl <= '0;
        else
            st_q <= st_d;
    end

    acia_rx_hold #(.RX_INIT(RX_INIT)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_take  (data_rd),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .rx_full_d(rx_full_d)
    );

    acia_tx_track u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_take   (data_wr),
        .wr_byte   (wdata),
        .tx_free   (tx_free),
        .tx_empty  (tx_empty),
        .tx_empty_d(tx_empty_d),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte)
    );

    acia_irq_eval u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl_d(st_d.ctrl),
        .rxf_d (rx_full_d),
        .txe_d (tx_empty_d),
        .irq   (irq)
    );

    always_comb begin
        status         = '0;
        status[ST_IRQ] = irq;
        status[ST_TXE] = tx_empty;
        status[ST_RXF] = rx_full;
    end

    assign rdata = reg_sel ? rx_data : status;
    assign irq_n = ~irq;

    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CR_RXIE] && rx_full) |-> !irq_n); // R2
    AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ctrl[CR_TXC_HI:CR_TXC_LO] == TXC_IRQ_ON) && tx_empty) |-> !irq_n); // R3
    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q.ctrl[CR_RXIE] && rx_full) &&
         !((st_q.ctrl[CR_TXC_HI:CR_TXC_LO] == TXC_IRQ_ON) && tx_empty)) |-> irq_n); // R4
    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (st_q.ctrl == $past(wdata))); // R6
    AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(st_q.ctrl)); // R11
endmodule

// File: tb/acia_regif_tb.sv
module acia_regif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, reg_sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_free = 1'b0;
    logic       tx_load;
    logic [7:0] tx_byte;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct {
        string      req;
        int         sel;   // 0 rdata, 1 irq_n, 2 tx_load, 3 tx_byte
        logic [7:0] val;
    } item_t;

    item_t exp_q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    acia_regif u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .reg_sel(reg_sel), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_free(tx_free), .tx_load(tx_load), .tx_byte(tx_byte)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                case (it.sel)
                    0:       act = rdata;
                    1:       act = {7'd0, irq_n};
                    2:       act = {7'd0, tx_load};
                    default: act = tx_byte;
                endcase
                total++;
                if (act !== it.val) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.val);
                end
            end
        end
    end

    task automatic expect_v(input string req, input int sel, input logic [7:0] val);
        item_t it;
        it.req = req; it.sel = sel; it.val = val;
        exp_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cs = 0; rd = 0; wr = 0; rx_valid = 0; tx_free = 0;
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] d);
        cs = 1; reg_sel = sel; wr = 1; wdata = d;
        step();
        idle();
    endtask

    task automatic peek(input string req, input logic sel, input logic [7:0] v);
        reg_sel = sel;
        #1;
        expect_v(req, 0, v);
    endtask

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1;
        // R7 / R1: reset contents
        peek("R7 status", 0, 8'h02);
        peek("R7 data", 1, 8'h01);
        expect_v("R7 irq_n", 1, 8'h01);
        // R6 R3: tx interrupt encoding 01
        bus_wr(0, 8'h20);
        peek("R3 status 01", 0, 8'h82);
        expect_v("R4 irq_n low", 1, 8'h00);
        bus_wr(0, 8'h40);
        peek("R3 status 10", 0, 8'h02);
        expect_v("R4 irq_n high", 1, 8'h01);
        bus_wr(0, 8'h60);
        peek("R3 status 11", 0, 8'h02);
        bus_wr(0, 8'h20);
        // R9: data write
        cs = 1; reg_sel = 1; wr = 1; wdata = 8'h5A;
        step();
        idle();
        expect_v("R9 load", 2, 8'h01);
        expect_v("R9 byte", 3, 8'h5A);
        peek("R9 txe cleared", 0, 8'h00);
        step();
        expect_v("R9 load one cycle", 2, 8'h00);
        // R10
        tx_free = 1; step(); idle();
        peek("R10 txe set", 0, 8'h82);
        // R9 priority over tx_free
        cs = 1; reg_sel = 1; wr = 1; wdata = 8'h33; tx_free = 1;
        step(); idle();
        expect_v("R9 byte 33", 3, 8'h33);
        peek("R9 write beats free", 0, 8'h00);
        tx_free = 1; step(); idle();
        bus_wr(0, 8'h80);
        peek("R6 ctrl 80", 0, 8'h02);
        // R8 R2
        rx_valid = 1; rx_byte = 8'hC3; step(); idle();
        peek("R2 status", 0, 8'h83);
        peek("R8 data", 1, 8'hC3);
        expect_v("R2 irq_n", 1, 8'h00);
        // R5
        cs = 1; reg_sel = 1; rd = 1;
        #1;
        expect_v("R5 read data", 0, 8'hC3);
        step(); idle();
        peek("R5 cleared", 0, 8'h02);
        expect_v("R5 irq_n", 1, 8'h01);
        // R8 overwrite
        rx_valid = 1; rx_byte = 8'hA1; step();
        rx_byte = 8'h7E; step(); idle();
        peek("R8 overwrite", 1, 8'h7E);
        // R8 rx beats read
        cs = 1; reg_sel = 1; rd = 1; rx_valid = 1; rx_byte = 8'h44;
        step(); idle();
        peek("R8 rx beats read", 0, 8'h83);
        peek("R8 data 44", 1, 8'h44);
        // R11 deselected strobes
        cs = 0; reg_sel = 1; rd = 1; step(); idle();
        peek("R11 read ignored", 0, 8'h83);
        cs = 0; reg_sel = 0; wr = 1; wdata = 8'h00; step(); idle();
        expect_v("R11 write ignored", 1, 8'h00);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule